// File: doc/BRIEF.md
# Data-Strobe Transmit Serializer

This block turns parallel link-layer words into a serial bit stream on a two-wire data-strobe pair. A system-clock register captures a word, a speed flag and a valid flag. The rest of the block runs on a fast bit clock at four times the system rate. It sends the captured bits out one after another, lowest index first. At full speed it sends all four bits of the word, one per fast cycle. At half speed it sends only the low two bits, and each bit stays on the line for two fast cycles.

The strobe wire carries the timing. It toggles only when a bit repeats the previous one, so exactly one of the two wires moves in every bit period and a receiver can recover the clock from data XOR strobe. The speed is chosen per transaction. When valid is low, the enable output drops and both wires hold their last level. Each new packet encodes as if the wires had started at 0/0.

The fast clock is derived from the same source as the system clock. Every fourth rising fast edge coincides with a rising system edge.

Top module: `ds_tx_serializer`

## Requirements
- R1: A synchronous active-high reset drives `dataLine`, `strobeLine` and `lineEn` to 0 and clears the captured word. The outputs stay at 0 until valid data is captured again.
- R2: With `txFast`=1, the word captured at a system edge appears on `dataLine` over the next four fast edges as `txData[0]`, `[1]`, `[2]`, `[3]`. The fourth of these edges is the one that coincides with the next system edge.
- R3: With `txFast`=0, only `txData[0]` and then `txData[1]` are sent, each held for two fast cycles. `txData[3:2]` has no effect on either wire.
- R4: When a new bit equals the previous bit, `strobeLine` toggles and `dataLine` stays put. When the new bit differs, `dataLine` changes and `strobeLine` stays put. The two wires never change on the same edge while a packet is in progress.
- R5: At full speed within a packet, `dataLine ^ strobeLine` inverts on every fast edge.
- R6: The first bit of a packet is encoded against a previous state of data=0, strobe=0. A first bit of 0 gives strobe=1. A first bit of 1 gives data=1, strobe=0.
- R7: While the captured valid flag is 0, `lineEn` is 0 and both wires hold their last value, whatever `txData` and `txFast` carry.
- R8: `lineEn` rises on the first fast edge after the system edge that captures `txValid`=1. It falls on the first fast edge after the system edge that captures `txValid`=0.
- R9: The speed may differ from one packet to the next. Each packet is serialized at the speed captured with its words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; parallel inputs are captured on its rising edge |
| bitClk | input | 1 | Fast bit clock, four times sysClk, edge-aligned |
| rst | input | 1 | Synchronous reset, active high, seen by both clocks |
| txData | input | 4 | Parallel word; bit 0 is sent first |
| txFast | input | 1 | 1 = four bits per system cycle, 0 = two bits |
| txValid | input | 1 | Word is part of a packet |
| dataLine | output | 1 | Encoded data wire |
| strobeLine | output | 1 | Strobe wire |
| lineEn | output | 1 | Output drivers enabled |

## Verification
The hardest case to reach is the fast edge that coincides with a system edge. On that edge the last bit of the old word must leave while the next word is being captured. A slip of one fast cycle in the capture or the slot counter shows up only there. The stimulus table therefore sends packets of back-to-back words whose bit patterns differ at that last slot. This includes all-zero and all-one words, which test the repeat path of the strobe across word boundaries. A reset asserted in the middle of a packet, followed by a fresh packet, tests that encoding restarts from the 0/0 state rather than from the interrupted one.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  // Widest parallel word (full speed) and the narrow word (half speed).
  localparam int WORD_W     = 4;
  localparam int SLOW_W     = 2;
  localparam int IDX_W      = $clog2(WORD_W);
  // Fast cycles per bit at half speed, as a power of two.
  localparam int SLOW_SHIFT = $clog2(WORD_W / SLOW_W);

  typedef struct packed {
    logic             live;   // captured valid flag
    logic             start;  // first fast edge of a packet
    logic             step;   // a new bit goes out on this edge
    logic [IDX_W-1:0] idx;    // bit of the captured word to send
  } dsCtrl_t;
endpackage

// File: rtl/ds_tx_ctrl.sv
module ds_tx_ctrl
  import ds_tx_pkg::*;
(
  input  logic    bitClk,
  input  logic    rst,
  input  logic    latValid,
  input  logic    latFast,
  output dsCtrl_t ctrl
);
  logic [IDX_W-1:0] slotCnt;
  logic             wasLive;
  logic             slowStep;

  // The slot counter starts at 0 on the first fast edge after capture.
  // It therefore stays phase-locked to the system clock for as long as
  // the packet lasts.
  always_ff @(posedge bitClk) begin
    if (rst) begin
      slotCnt <= '0;
      wasLive <= 1'b0;
    end else begin
      wasLive <= latValid;
      slotCnt <= latValid ? slotCnt + IDX_W'(1) : '0;
    end
  end

  generate
    if (SLOW_SHIFT == 0) begin : g_noDiv
      assign slowStep = 1'b1;
    end else begin : g_div
      assign slowStep = (slotCnt[SLOW_SHIFT-1:0] == '0);
    end
  endgenerate

  always_comb begin
    ctrl.live  = latValid;
    ctrl.start = latValid && !wasLive;
    ctrl.step  = latValid && (latFast || slowStep);
    ctrl.idx   = latFast ? slotCnt : IDX_W'(slotCnt >> SLOW_SHIFT);
  end
endmodule

// File: rtl/ds_tx_datapath.sv
module ds_tx_datapath
  import ds_tx_pkg::*;
(
  input  logic              sysClk,
  input  logic              bitClk,
  input  logic              rst,
  input  logic [WORD_W-1:0] txData,
  input  logic              txFast,
  input  logic              txValid,
  input  dsCtrl_t           ctrl,
  output logic              latValid,
  output logic              latFast,
  output logic              dataLine,
  output logic              strobeLine,
  output logic              lineEn
);
  logic [WORD_W-1:0] latWord;
  logic              nextBit;
  logic              prevData;
  logic              prevStrobe;

  // System-clock capture of the parallel word.
  always_ff @(posedge sysClk) begin
    if (rst) begin
      latWord  <= '0;
      latFast  <= 1'b0;
      latValid <= 1'b0;
    end else begin
      latWord  <= txData;
      latFast  <= txFast;
      latValid <= txValid;
    end
  end

  assign nextBit    = latWord[ctrl.idx];
  // A packet starts from a fresh 0/0 line state.
  assign prevData   = ctrl.start ? 1'b0 : dataLine;
  assign prevStrobe = ctrl.start ? 1'b0 : strobeLine;

  // Fast-clock encoder.
  always_ff @(posedge bitClk) begin
    if (rst) begin
      dataLine   <= 1'b0;
      strobeLine <= 1'b0;
      lineEn     <= 1'b0;
    end else begin
      lineEn <= ctrl.live;
      if (ctrl.step) begin
        dataLine   <= nextBit;
        strobeLine <= (nextBit == prevData) ? ~prevStrobe : prevStrobe;
      end
    end
  end
endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
  import ds_tx_pkg::*;
(
  input  logic              sysClk,
  input  logic              bitClk,
  input  logic              rst,
  input  logic [WORD_W-1:0] txData,
  input  logic              txFast,
  input  logic              txValid,
  output logic              dataLine,
  output logic              strobeLine,
  output logic              lineEn
);
  dsCtrl_t ctrl;
  logic    latValid;
  logic    latFast;

  ds_tx_ctrl u_ctrl (
    .bitClk   (bitClk),
    .rst      (rst),
    .latValid (latValid),
    .latFast  (latFast),
    .ctrl     (ctrl)
  );

  ds_tx_datapath u_dp (
    .sysClk     (sysClk),
    .bitClk     (bitClk),
    .rst        (rst),
    .txData     (txData),
    .txFast     (txFast),
    .txValid    (txValid),
    .ctrl       (ctrl),
    .latValid   (latValid),
    .latFast    (latFast),
    .dataLine   (dataLine),
    .strobeLine (strobeLine),
    .lineEn     (lineEn)
  );
endmodule

// File: rtl/ds_tx_chk.sv
module ds_tx_chk (
  input logic bitClk,
  input logic rst,
  input logic dataLine,
  input logic strobeLine,
  input logic lineEn,
  input logic latFast
);
  // R7
  idle_hold_chk: assert property (@(posedge bitClk) disable iff (rst)
    !lineEn |-> ($stable(dataLine) && $stable(strobeLine)));

  // R4
  one_wire_moves_chk: assert property (@(posedge bitClk) disable iff (rst)
    (lineEn && $past(lineEn)) |-> !($changed(dataLine) && $changed(strobeLine)));

  // R5
  fast_toggle_chk: assert property (@(posedge bitClk) disable iff (rst)
    (lineEn && $past(lineEn) && $past(latFast))
      |-> ((dataLine ^ strobeLine) != $past(dataLine ^ strobeLine)));

  // R6
  start_pair_chk: assert property (@(posedge bitClk) disable iff (rst)
    $rose(lineEn) |-> (strobeLine != dataLine));
endmodule

bind ds_tx_serializer ds_tx_chk u_chk (
  .bitClk     (bitClk),
  .rst        (rst),
  .dataLine   (dataLine),
  .strobeLine (strobeLine),
  .lineEn     (lineEn),
  .latFast    (latFast)
);

// File: tb/ds_tx_serializer_bench.sv
module ds_tx_serializer_bench;
  localparam int CLK_PERIOD = 40;            // system clock period
  localparam int HALF_BIT   = CLK_PERIOD / 8;
  localparam int NVEC       = 16;
  // Each entry is {valid, fast, word[3:0]}.
  localparam logic [5:0] VEC [NVEC] = '{
    6'b11_0000, 6'b11_1111, 6'b11_1010, 6'b11_0110,
    6'b00_0000, 6'b00_1111,
    6'b10_1101, 6'b10_1110, 6'b10_0011, 6'b10_1100,
    6'b00_0000,
    6'b11_0001, 6'b11_1000,
    6'b00_0110,
    6'b10_0101,
    6'b00_0000
  };

  logic       sysClk = 1'b0, bitClk = 1'b0, rst = 1'b1;
  logic [3:0] txData = '0;
  logic       txFast = 1'b0, txValid = 1'b0;
  logic       dataLine, strobeLine, lineEn;

  int   nChecks = 0, nFails = 0;
  int   ph = 0, curPh = 0;
  logic [5:0] lat = '0, prevLat = '0;
  logic eD = 0, eS = 0, eEn = 0, lastPktFast = 0, haveModel = 0;

  ds_tx_serializer u_ds_tx_serializer (
    .sysClk(sysClk), .bitClk(bitClk), .rst(rst),
    .txData(txData), .txFast(txFast), .txValid(txValid),
    .dataLine(dataLine), .strobeLine(strobeLine), .lineEn(lineEn)
  );

  // Edge-aligned clocks: sysClk rises on every fourth bitClk rise.
  initial begin
    forever begin
      #HALF_BIT;
      bitClk = 1'b1;
      curPh = ph;
      if (ph == 0) sysClk = 1'b1;
      if (ph == 2) sysClk = 1'b0;
      ph = (ph + 1) % 4;
      #HALF_BIT;
      bitClk = 1'b0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench copy of the system-edge capture.
  always @(posedge sysClk) begin
    if (rst) begin lat <= '0; prevLat <= '0; end
    else begin prevLat <= lat; lat <= {txValid, txFast, txData}; end
  end

  // Reference encoder, sampled away from the clock edge.
  always @(negedge bitClk) begin : smp
    logic [5:0] src;
    int slot, bi;
    logic fast, step, b, pd, ps, first, oldX;
    string tg;
    if (rst) begin
      eD = 0; eS = 0; eEn = 0; haveModel = 1;
    end else if (haveModel) begin
      src   = (curPh == 0) ? prevLat : lat;
      slot  = (curPh == 0) ? 3 : curPh - 1;
      fast  = src[4];
      first = src[5] && !eEn;
      oldX  = eD ^ eS;
      if (src[5]) begin
        step = fast || (slot % 2 == 0);
        if (step) begin
          bi = fast ? slot : slot / 2;
          b  = src[bi];
          pd = first ? 1'b0 : eD;
          ps = first ? 1'b0 : eS;
          eD = b;
          eS = (b == pd) ? ~ps : ps;
        end
      end
      if (!src[5])       tg = "R7";
      else if (first)    tg = (fast != lastPktFast) ? "R9" : "R6";
      else if (fast)     tg = "R2";
      else               tg = "R3";
      if (first) lastPktFast = fast;
      check(tg, dataLine, eD);
      check("R4", strobeLine, eS);
      check("R8", lineEn, src[5]);
      if (src[5] && fast && eEn)
        check("R5", dataLine ^ strobeLine, ~oldX);
      eEn = src[5];
    end
  end

  task automatic drive(input logic [5:0] v);
    @(negedge sysClk);
    #1;
    txValid = v[5]; txFast = v[4]; txData = v[3:0];
  endtask

  initial begin
    repeat (3) @(negedge sysClk);
    #1 rst = 1'b0;
    @(negedge bitClk);
    // R1: reset state
    check("R1", dataLine, 1'b0);
    check("R1", strobeLine, 1'b0);
    check("R1", lineEn, 1'b0);

    for (int i = 0; i < NVEC; i++) drive(VEC[i]);
    drive(6'b00_0000);
    drive(6'b00_0000);

    // Reset in the middle of a full-speed packet, then a new packet.
    drive(6'b11_1111);
    drive(6'b11_1111);
    @(negedge sysClk);
    #1 rst = 1'b1; txValid = 1'b0;
    repeat (2) @(negedge sysClk);
    #1 rst = 1'b0;
    @(negedge bitClk);
    check("R1", dataLine, 1'b0);
    check("R1", strobeLine, 1'b0);
    check("R1", lineEn, 1'b0);
    drive(6'b11_0011);
    drive(6'b11_0101);
    drive(6'b00_0000);
    drive(6'b00_0000);
    repeat (2) @(negedge sysClk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule